// File: doc/BRIEF.md
# Paired-Single Cross-Lane Reduction Adder

This block adds horizontally inside packed pairs of single-precision floats. Each of the two 64-bit operands carries two IEEE-754 binary32 values, one in bits 63:32 and one in bits 31:0. The block sums the two halves of operand A into the upper half of the result, and the two halves of operand B into the lower half. A four-term dot product is usually left as two partial sums per lane, and this block collapses them. One operation does the work of two lane shuffles followed by a packed add.

Two identical single-precision lane adders run side by side in a fixed four-stage pipeline with no back-pressure. An operation can be accepted on every clock. Its result comes out, flagged by `out_valid`, a fixed number of cycles later. Rounding is round-to-nearest-even. Subnormal inputs and subnormal results are both replaced by signed zero. Infinities follow IEEE rules, and infinity plus the opposite infinity gives the default quiet NaN. NaN inputs and floating-point exception flags are outside this block's scope.

Top module: `ps_cross_adder`

## Requirements
- R1: `result[63:32]` equals the correctly rounded sum of `op_a[63:32]` and `op_a[31:0]`.
- R2: `result[31:0]` equals the correctly rounded sum of `op_b[63:32]` and `op_b[31:0]`.
- R3: An operation sampled with `in_valid` high on a rising edge shows up on `result` with `out_valid` high after the fourth rising edge, counting the sampling edge as the first. A new operation may be sampled on every edge, and the results appear in issue order.
- R4: Rounding is to nearest. An exact tie is broken toward the value whose fraction LSB (bit 0) is 0.
- R5: An input with exponent field 0 acts as a zero with the same sign. A nonzero fraction does not change this.
- R6: A sum whose magnitude after rounding is below 2^-126 is returned as zero with the sign of the larger-magnitude operand, as 0x00000000 or 0x80000000.
- R7: A finite sum that overflows after rounding is returned as infinity of that sign: 0x7F800000 or 0xFF800000.
- R8: If exactly one input is infinity, or both are infinities of the same sign, the lane returns that infinity.
- R9: +infinity plus -infinity, in either order, returns 0x7FC00000.
- R10: While `rst_n` is low, and afterwards until a new operation completes, `out_valid` is 0. Operations in flight when reset is asserted never emerge.
- R11: Two nonzero inputs of equal magnitude and opposite sign sum to +0 (0x00000000). Two zeros of the same sign keep that sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 64 | Packed pair whose halves form the upper result lane |
| op_b | input | 64 | Packed pair whose halves form the lower result lane |
| out_valid | output | 1 | `result` holds a completed operation |
| result | output | 64 | {sum of op_a halves, sum of op_b halves} |

## Verification
Both lane sums of an operation are due together, four rising edges after `in_valid` is sampled. Each operation leaves on the same cycle with no per-lane skew, and it must not arrive one cycle early or late. The driver stamps each expected item with the cycle count at issue. The monitor samples on the falling edge and requires that `out_valid` arrives exactly four counts later. Some operations are issued back to back and others with idle gaps, so both dense and sparse traffic keep that spacing. One burst is cut off by reset to show that nothing emerges afterwards.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int EW   = 8;          // exponent field width
  localparam int FW   = 23;         // fraction field width
  localparam int DW   = 1 + EW + FW; // one lane
  localparam int MW   = FW + 1;     // mantissa with hidden bit
  localparam int AW   = MW + 2;     // aligned mantissa plus guard and round
  localparam int SW   = MW + 3;     // sum width below the carry bit
  localparam int NW   = FW + 3;     // normalized fraction plus G, R, S
  localparam int XW   = EW + 2;     // signed working exponent
  localparam int LAT  = 4;          // pipeline depth
  localparam int NLANE = 2;
  localparam int FARSH = 32;        // beyond this the small operand is pure sticky
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [DW-1:0] QNAN = 32'h7FC0_0000;

  typedef struct packed {
    logic          sgn;
    logic          sub;
    logic [EW-1:0] exp;
    logic [EW-1:0] dif;
    logic [MW-1:0] mb;
    logic [MW-1:0] ms;
    logic          inf;
    logic          nan;
    logic          isg;
  } st1_t;

  typedef struct packed {
    logic          sgn;
    logic          sub;
    logic [EW-1:0] exp;
    logic [MW-1:0] mb;
    logic [AW-1:0] al;
    logic          stk;
    logic          inf;
    logic          nan;
    logic          isg;
  } st2_t;

  typedef struct packed {
    logic          sgn;
    logic          zero;
    logic [XW-1:0] exp;
    logic [NW-1:0] frac;
    logic          inf;
    logic          nan;
    logic          isg;
  } st3_t;

  function automatic logic [4:0] lead_zeros(input logic [SW-1:0] v);
    logic [4:0] c;
    c = 5'(SW);
    for (int i = 0; i < SW; i++) begin
      if (v[i]) c = 5'(SW - 1 - i);
    end
    return c;
  endfunction
endpackage

// File: rtl/ps_valid_pipe.sv
module ps_valid_pipe
  import ps_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_v,
  output logic [LAT-1:0] v
);
  logic [LAT-1:0] v_q, v_d;

  always_comb v_d = {v_q[LAT-2:0], in_v};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  assign v = v_q;

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q[LAT-1] |-> $past(in_v, 4));
endmodule

// File: rtl/ps_lane_add.sv
module ps_lane_add
  import ps_pkg::*;
(
  input  logic           clk,
  input  logic [LAT-1:0] en,
  input  logic [DW-1:0]  op_x,
  input  logic [DW-1:0]  op_y,
  output logic [DW-1:0]  sum_o
);
  // stage 1: classify, flush subnormals, order by magnitude
  logic [EW-1:0] ex, ey;
  logic [DW-2:0] kx, ky;
  logic          x_inf, y_inf, swap;
  st1_t          s1_d, s1_q;

  assign ex    = op_x[DW-2:FW];
  assign ey    = op_y[DW-2:FW];
  assign x_inf = (ex == EMAX);
  assign y_inf = (ey == EMAX);
  assign kx    = (ex == '0) ? '0 : op_x[DW-2:0];
  assign ky    = (ey == '0) ? '0 : op_y[DW-2:0];
  assign swap  = (ky > kx);

  always_comb begin
    s1_d.sgn = swap ? op_y[DW-1] : op_x[DW-1];
    s1_d.sub = op_x[DW-1] ^ op_y[DW-1];
    s1_d.exp = swap ? ey : ex;
    s1_d.dif = swap ? (ey - ex) : (ex - ey);
    s1_d.mb  = swap ? {|ey, ky[FW-1:0]} : {|ex, kx[FW-1:0]};
    s1_d.ms  = swap ? {|ex, kx[FW-1:0]} : {|ey, ky[FW-1:0]};
    s1_d.inf = x_inf | y_inf;
    s1_d.nan = x_inf & y_inf & (op_x[DW-1] != op_y[DW-1]);
    s1_d.isg = x_inf ? op_x[DW-1] : op_y[DW-1];
  end

  always_ff @(posedge clk) begin
    if (en[0]) s1_q <= s1_d;
  end

  // stage 2: align the smaller mantissa, collect sticky
  logic [MW+AW-1:0] wide, sh;
  st2_t             s2_d, s2_q;

  assign wide = {s1_q.ms, {AW{1'b0}}};
  assign sh   = wide >> s1_q.dif;

  always_comb begin
    s2_d.sgn = s1_q.sgn;
    s2_d.sub = s1_q.sub;
    s2_d.exp = s1_q.exp;
    s2_d.mb  = s1_q.mb;
    s2_d.inf = s1_q.inf;
    s2_d.nan = s1_q.nan;
    s2_d.isg = s1_q.isg;
    if (s1_q.dif >= EW'(FARSH)) begin
      s2_d.al  = '0;
      s2_d.stk = |s1_q.ms;
    end else begin
      s2_d.al  = sh[MW+AW-1:MW];
      s2_d.stk = |sh[MW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (en[1]) s2_q <= s2_d;
  end

  // stage 3: add or subtract, normalize
  logic [SW:0]   opx, opy, raw;
  logic [4:0]    lz;
  st3_t          s3_d, s3_q;

  assign opx = {1'b0, s2_q.mb, 3'b000};
  assign opy = {1'b0, s2_q.al, s2_q.stk};
  assign raw = s2_q.sub ? (opx - opy) : (opx + opy);
  assign lz  = lead_zeros(raw[SW-1:0]);

  always_comb begin
    s3_d.inf  = s2_q.inf;
    s3_d.nan  = s2_q.nan;
    s3_d.isg  = s2_q.isg;
    s3_d.zero = (raw == '0);
    s3_d.sgn  = (raw == '0 && s2_q.sub) ? 1'b0 : s2_q.sgn;
    if (raw[SW]) begin
      s3_d.frac = {raw[SW-1:2], raw[1] | raw[0]};
      s3_d.exp  = XW'($signed({2'b00, s2_q.exp}) + 10'sd1);
    end else begin
      s3_d.frac = raw[NW-1:0] << lz;
      s3_d.exp  = XW'($signed({2'b00, s2_q.exp}) - $signed({5'b00000, lz}));
    end
  end

  always_ff @(posedge clk) begin
    if (en[2]) s3_q <= s3_d;
  end

  // stage 4: round to nearest even, pack
  logic              rup;
  logic [MW-1:0]     rnd;
  logic signed [XW-1:0] efin;
  logic [DW-1:0]     s4_d, s4_q;

  assign rup  = s3_q.frac[2] & (s3_q.frac[1] | s3_q.frac[0] | s3_q.frac[3]);
  assign rnd  = {1'b0, s3_q.frac[NW-1:3]} + MW'(rup);
  assign efin = $signed(s3_q.exp) + $signed({{(XW-1){1'b0}}, rnd[MW-1]});

  always_comb begin
    if (s3_q.nan)                         s4_d = QNAN;
    else if (s3_q.inf)                    s4_d = {s3_q.isg, EMAX, {FW{1'b0}}};
    else if (s3_q.zero || efin <= 0)      s4_d = {s3_q.sgn, {(DW-1){1'b0}}};
    else if (efin >= $signed(XW'(EMAX)))  s4_d = {s3_q.sgn, EMAX, {FW{1'b0}}};
    else                                  s4_d = {s3_q.sgn, efin[EW-1:0], rnd[FW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (en[3]) s4_q <= s4_d;
  end

  assign sum_o = s4_q;
endmodule

// File: rtl/ps_cross_adder.sv
module ps_cross_adder
  import ps_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*DW-1:0]     op_a,
  input  logic [2*DW-1:0]     op_b,
  output logic                out_valid,
  output logic [2*DW-1:0]     result
);
  logic [LAT-1:0]            vld;
  logic [LAT-1:0]            en;
  logic [NLANE-1:0][2*DW-1:0] src;
  logic [NLANE-1:0][DW-1:0]  lane_sum;

  ps_valid_pipe i_vpipe (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (in_valid),
    .v     (vld)
  );

  assign en  = {vld[LAT-2:0], in_valid};
  assign src = {op_a, op_b};   // lane 1 (upper) reduces op_a, lane 0 reduces op_b

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    ps_lane_add i_lane (
      .clk   (clk),
      .en    (en),
      .op_x  (src[g][2*DW-1:DW]),
      .op_y  (src[g][DW-1:0]),
      .sum_o (lane_sum[g])
    );
  end

  assign result    = lane_sum;
  assign out_valid = vld[LAT-1];

  // R8
  inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && op_a[62:55] == 8'hFF && op_a[54:32] == '0
                        && op_a[30:23] != 8'hFF, 4))
    |-> result[63:32] == {$past(op_a[63], 4), 8'hFF, 23'd0});

  // R9
  nan_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && op_b[62:55] == 8'hFF && op_b[30:23] == 8'hFF
                        && op_b[54:32] == '0 && op_b[22:0] == '0
                        && op_b[63] != op_b[31], 4))
    |-> result[31:0] == 32'h7FC0_0000);

  // R5
  denorm_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid && op_a[30:23] == 8'h00 && op_a[62:55] != 8'h00
                        && op_a[62:55] != 8'hFF, 4))
    |-> result[63:32] == $past(op_a[63:32], 4));

  // R6
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(result[62:55] == 8'h00 && result[54:32] != '0)
               && !(result[30:23] == 8'h00 && result[22:0] != '0));
endmodule

// File: tb/test_ps_cross_adder.sv
`timescale 1ns/1ps
module test_ps_cross_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  int          stamp_q[$];

  ps_cross_adder i_ps_cross_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
  );

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [31:0] ah, input logic [31:0] al,
                       input logic [31:0] bh, input logic [31:0] bl,
                       input logic [31:0] eh, input logic [31:0] el,
                       input string tag, input bit push);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = {ah, al};
    op_b = {bh, bl};
    if (push) begin
      exp_q.push_back({eh, el});
      tag_q.push_back(tag);
      stamp_q.push_back(cyc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops one expected item per result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected result", result, '0);
      end else begin
        logic [63:0] e;
        string t;
        int s;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        s = stamp_q.pop_front();
        check(result[63:32] == e[63:32], {"R1 upper lane ", t}, {32'd0, result[63:32]}, {32'd0, e[63:32]});
        check(result[31:0]  == e[31:0],  {"R2 lower lane ", t}, {32'd0, result[31:0]},  {32'd0, e[31:0]});
        check(cyc == s + 4, {"R3 latency ", t}, 64'(cyc - s), 64'd4);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10 during reset", {63'd0, out_valid}, '0);
    end
    @(negedge clk) rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10 after release", {63'd0, out_valid}, '0);
    end

    // back-to-back burst
    issue(32'h3F800000, 32'h40000000, 32'h3FC00000, 32'h40200000,
          32'h40400000, 32'h40800000, "R1 R2 basic", 1'b1);
    issue(32'h40600000, 32'h3E800000, 32'h40400000, 32'hBF800000,
          32'h40700000, 32'h40000000, "R1 R2 mixed sign", 1'b1);
    issue(32'h3F800000, 32'hBF800000, 32'hBF800000, 32'h3F800000,
          32'h00000000, 32'h00000000, "R11 cancel", 1'b1);
    issue(32'h80000000, 32'h80000000, 32'h00000000, 32'h00000000,
          32'h80000000, 32'h00000000, "R11 signed zeros", 1'b1);
    issue(32'h3F800000, 32'h33800000, 32'h3F800001, 32'h33800000,
          32'h3F800000, 32'h3F800002, "R4 ties to even", 1'b1);
    issue(32'h3F800000, 32'h33C00000, 32'h4B800000, 32'h40400000,
          32'h3F800001, 32'h4B800002, "R4 above half", 1'b1);
    issue(32'h4B800000, 32'h3F800000, 32'h3F800000, 32'hB0800000,
          32'h4B800000, 32'h3F800000, "R4 far sub", 1'b1);
    idle(2);

    // sparse traffic
    issue(32'h7F7FFFFF, 32'h7F7FFFFF, 32'hFF7FFFFF, 32'hFF7FFFFF,
          32'h7F800000, 32'hFF800000, "R7 overflow", 1'b1);
    idle(1);
    issue(32'h3F800000, 32'h3F800000, 32'h7F7FFFFF, 32'h73000000,
          32'h40000000, 32'h7F800000, "R7 round overflow", 1'b1);
    idle(3);
    issue(32'h00C00000, 32'h80800000, 32'h80C00000, 32'h00800000,
          32'h00000000, 32'h80000000, "R6 underflow", 1'b1);
    issue(32'h00000001, 32'h3F800000, 32'h80000001, 32'h80000001,
          32'h3F800000, 32'h80000000, "R5 subnormal in", 1'b1);
    idle(1);
    issue(32'h7F800000, 32'h3F800000, 32'h42000000, 32'hFF800000,
          32'h7F800000, 32'hFF800000, "R8 one inf", 1'b1);
    issue(32'h7F800000, 32'hFF800000, 32'hFF800000, 32'h7F800000,
          32'h7FC00000, 32'h7FC00000, "R9 opposite inf", 1'b1);
    issue(32'hFF800000, 32'hFF800000, 32'h7F800000, 32'h00000005,
          32'hFF800000, 32'h7F800000, "R8 same inf", 1'b1);
    idle(8);

    // R10: flush in-flight work with reset
    issue(32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000, '0, '0, "", 1'b0);
    issue(32'h40000000, 32'h40000000, 32'h40000000, 32'h40000000, '0, '0, "", 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 mid-run reset", {63'd0, out_valid}, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10 flushed work", {63'd0, out_valid}, '0);
    end

    // post-reset operation still works
    issue(32'h40000000, 32'h40000000, 32'h3F800000, 32'h40000000,
          32'h40800000, 32'h40400000, "R1 R2 after reset", 1'b1);
    idle(8);

    check(exp_q.size() == 0, "R3 all results seen", 64'(exp_q.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule